// File: doc/BRIEF.md
# Per-Source Replay Filter

This block sits in the data path of a switch that folds key-value traffic from many senders into shared state. It keeps one sequence watermark per sender and judges each arriving data packet. A packet that is new is passed on to the reduction logic. A retransmission of a packet that was already folded in is discarded, so the aggregated results are never updated twice. For every accepted packet the block also produces an acknowledgement descriptor. The descriptor carries the same sequence number and the same sender, with the source and destination addresses swapped, so that it can be returned to the sender. A sender that sees a gap in the returned sequence numbers retransmits.

Each watermark starts unset. The first packet from a sender is always accepted, and its sequence number becomes that sender's watermark. After that, a packet is accepted only if its sequence number is strictly above the watermark. When the downstream logic finishes with an accepted packet, it pulses a completion strobe that names the sender, and the watermark advances by one. The completion for the seeding packet is absorbed, because the seed already records that packet. A completion in the same cycle as a new packet from the same sender is forwarded into that packet's comparison. A synchronous clear makes every watermark unset again at the start of a new job.

Top module: `seq_guard`

## Requirements
- R1: While reset is applied and in the first cycle after it, `accept_o`, `drop_o` and `ack_valid_o` are 0, and every sender's watermark is unset.
- R2: A packet from a sender whose watermark is unset is accepted whatever its sequence number, 0 and 0xFFFFFFFF included, and that sequence number becomes the sender's watermark.
- R3: A packet from a sender with a set watermark is accepted when its sequence number is above the watermark and dropped when it is equal to or below it. The comparison is unsigned over `SEQ_W` bits.
- R4: A `done_i` pulse for an initialised sender raises its watermark by one. The exception is the first pulse after the seeding packet, which leaves the watermark unchanged.
- R5: When `done_i` names the same sender as a packet in the same cycle, the packet is compared against the watermark as it stands after that completion.
- R6: A `done_i` pulse for a sender whose watermark is unset has no effect. The next packet from that sender is still accepted as a first packet.
- R7: `clear_i` makes every watermark unset, and a `done_i` pulse in the same cycle is ignored. A packet presented in the same cycle as the clear is judged as a first packet and seeds its sender's watermark.
- R8: One cycle after an accepted packet, `ack_valid_o` is 1. In that cycle `ack_src_o` and `ack_seq_o` equal the packet's sender and sequence number, `ack_saddr_o` equals the packet's destination address, and `ack_daddr_o` equals its source address. A dropped packet produces no acknowledgement.
- R9: Each cycle with `pkt_valid_i` high gives exactly one of `accept_o` or `drop_o` in the next cycle. A cycle without a packet gives neither.
- R10: The watermarks of different senders are independent: packets and completions for one sender never change the judgement of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous job start: unset all watermarks |
| pkt_valid_i | input | 1 | Packet descriptor present this cycle |
| pkt_src_i | input | SRC_W | Sender index of the packet |
| pkt_seq_i | input | SEQ_W | Sequence number of the packet |
| pkt_saddr_i | input | ADDR_W | Source address of the packet |
| pkt_daddr_i | input | ADDR_W | Destination address of the packet |
| done_i | input | 1 | Processing of an accepted packet has completed |
| done_src_i | input | SRC_W | Sender of the completed packet |
| accept_o | output | 1 | Previous cycle's packet is new |
| drop_o | output | 1 | Previous cycle's packet is a replay |
| ack_valid_o | output | 1 | Acknowledgement descriptor valid |
| ack_src_o | output | SRC_W | Sender the acknowledgement returns to |
| ack_seq_o | output | SEQ_W | Acknowledged sequence number |
| ack_saddr_o | output | ADDR_W | Acknowledgement source address (packet destination) |
| ack_daddr_o | output | ADDR_W | Acknowledgement destination address (packet source) |

## Verification
The bench uses a four-sender configuration. It first drives directed patterns. Sequence numbers just below, at and just above a watermark separate a strict comparison from a non-strict one. Seeds of 0 and 0xFFFFFFFF show that the first-packet rule ignores the value. Completion pulses on the seeding packet and on later packets separate the absorbed completion from the advancing one. A completion coincident with a packet from the same sender tells forwarding apart from a stale read. A completion for an unset sender and a clear coincident with both a packet and a completion cover the ignore paths. A long pseudo-random mix then interleaves all senders, completions and occasional clears. It checks every verdict and acknowledgement against a watermark model kept in the bench, which catches any cross-sender leakage.

// File: rtl/seq_guard_pkg.sv
package seq_guard_pkg;

  typedef enum logic [1:0] {
    VERD_NONE = 2'd0,
    VERD_TAKE = 2'd1,
    VERD_DROP = 2'd2
  } verdict_e;

endpackage

// File: rtl/seq_guard_entry.sv
module seq_guard_entry #(
  parameter int SEQ_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             seed_i,
  input  logic [SEQ_W-1:0] seed_val_i,
  input  logic             done_i,
  output logic             init_o,
  output logic             pend_o,
  output logic [SEQ_W-1:0] mark_o
);

  logic             init_q;
  logic             pend_q;
  logic [SEQ_W-1:0] mark_q;

  // seed outranks clear: a packet in the clear cycle starts the new job
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      pend_q <= 1'b0;
      mark_q <= '0;
    end else if (seed_i) begin
      init_q <= 1'b1;
      pend_q <= 1'b1;
      mark_q <= seed_val_i;
    end else if (clear_i) begin
      init_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (done_i && init_q) begin
      if (pend_q) pend_q <= 1'b0;
      else        mark_q <= mark_q + SEQ_W'(1);
    end
  end

  assign init_o = init_q;
  assign pend_o = pend_q;
  assign mark_o = mark_q;

  // R2: seeding records the sequence number
  a_r2_seed_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_i |=> (init_o && pend_o && mark_o == $past(seed_val_i)));

  // R4: completion after the seed advances by exactly one
  a_r4_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && init_o && !pend_o && !clear_i && !seed_i) |=> (mark_o == $past(mark_o) + SEQ_W'(1)));

  // R6: completion on an unset entry leaves it unset
  a_r6_idle_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !init_o && !seed_i) |=> !init_o);

  // R7: clear unsets the entry
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !seed_i) |=> (!init_o && !pend_o));

endmodule

// File: rtl/seq_guard_judge.sv
module seq_guard_judge
  import seq_guard_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int SEQ_W = 32,
  parameter int SRC_W = 2
) (
  input  logic                       pkt_valid_i,
  input  logic [SRC_W-1:0]           pkt_src_i,
  input  logic [SEQ_W-1:0]           pkt_seq_i,
  input  logic                       clear_i,
  input  logic                       done_i,
  input  logic [SRC_W-1:0]           done_src_i,
  input  logic [N_SRC-1:0]           init_i,
  input  logic [N_SRC-1:0]           pend_i,
  input  logic [N_SRC-1:0][SEQ_W-1:0] mark_i,
  output verdict_e                   verdict_o,
  output logic [N_SRC-1:0]           seed_o
);

  localparam logic [SRC_W:0] SRC_LIM = (SRC_W+1)'(N_SRC);

  logic             sel_init;
  logic             sel_pend;
  logic [SEQ_W-1:0] sel_mark;
  logic             in_range;
  logic             eff_init;
  logic             fwd;
  logic [SEQ_W-1:0] eff_mark;
  logic             take;

  always_comb begin
    sel_init = 1'b0;
    sel_pend = 1'b0;
    sel_mark = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pkt_src_i == SRC_W'(i)) begin
        sel_init = init_i[i];
        sel_pend = pend_i[i];
        sel_mark = mark_i[i];
      end
    end
  end

  assign in_range = ({1'b0, pkt_src_i} < SRC_LIM);
  assign eff_init = sel_init && !clear_i;
  // completion landing this cycle on the same entry is seen by the compare
  assign fwd      = done_i && (done_src_i == pkt_src_i) && eff_init && !sel_pend;
  assign eff_mark = fwd ? sel_mark + SEQ_W'(1) : sel_mark;
  assign take     = in_range && (!eff_init || (pkt_seq_i > eff_mark));

  always_comb begin
    if (!pkt_valid_i) verdict_o = VERD_NONE;
    else if (take)    verdict_o = VERD_TAKE;
    else              verdict_o = VERD_DROP;
  end

  always_comb begin
    for (int i = 0; i < N_SRC; i++)
      seed_o[i] = pkt_valid_i && in_range && !eff_init && (pkt_src_i == SRC_W'(i));
  end

  // R2: at most one entry seeds per packet
  always_comb begin
    a_r2_seed_onehot: assert ($onehot0(seed_o));
  end

endmodule

// File: rtl/seq_guard_ack.sv
module seq_guard_ack
  import seq_guard_pkg::*;
#(
  parameter int SEQ_W  = 32,
  parameter int SRC_W  = 2,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  verdict_e          verdict_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [SEQ_W-1:0]  seq_i,
  input  logic [ADDR_W-1:0] saddr_i,
  input  logic [ADDR_W-1:0] daddr_i,
  output logic              accept_o,
  output logic              drop_o,
  output logic              ack_valid_o,
  output logic [SRC_W-1:0]  ack_src_o,
  output logic [SEQ_W-1:0]  ack_seq_o,
  output logic [ADDR_W-1:0] ack_saddr_o,
  output logic [ADDR_W-1:0] ack_daddr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o    <= 1'b0;
      drop_o      <= 1'b0;
      ack_valid_o <= 1'b0;
    end else begin
      accept_o    <= (verdict_i == VERD_TAKE);
      drop_o      <= (verdict_i == VERD_DROP);
      ack_valid_o <= (verdict_i == VERD_TAKE);
    end
  end

  // payload registers load only on accept; no reset needed
  always_ff @(posedge clk_i) begin
    if (verdict_i == VERD_TAKE) begin
      ack_src_o   <= src_i;
      ack_seq_o   <= seq_i;
      ack_saddr_o <= daddr_i;
      ack_daddr_o <= saddr_i;
    end
  end

endmodule

// File: rtl/seq_guard.sv
module seq_guard
  import seq_guard_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int SEQ_W  = 32,
  parameter int ADDR_W = 32,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              pkt_valid_i,
  input  logic [SRC_W-1:0]  pkt_src_i,
  input  logic [SEQ_W-1:0]  pkt_seq_i,
  input  logic [ADDR_W-1:0] pkt_saddr_i,
  input  logic [ADDR_W-1:0] pkt_daddr_i,
  input  logic              done_i,
  input  logic [SRC_W-1:0]  done_src_i,
  output logic              accept_o,
  output logic              drop_o,
  output logic              ack_valid_o,
  output logic [SRC_W-1:0]  ack_src_o,
  output logic [SEQ_W-1:0]  ack_seq_o,
  output logic [ADDR_W-1:0] ack_saddr_o,
  output logic [ADDR_W-1:0] ack_daddr_o
);

  logic [N_SRC-1:0]            init_w;
  logic [N_SRC-1:0]            pend_w;
  logic [N_SRC-1:0][SEQ_W-1:0] mark_w;
  logic [N_SRC-1:0]            seed_w;
  logic [N_SRC-1:0]            done_w;
  verdict_e                    verdict_w;

  for (genvar g = 0; g < N_SRC; g++) begin : g_entry
    assign done_w[g] = done_i && (done_src_i == SRC_W'(g));

    seq_guard_entry #(
      .SEQ_W (SEQ_W)
    ) u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (clear_i),
      .seed_i     (seed_w[g]),
      .seed_val_i (pkt_seq_i),
      .done_i     (done_w[g]),
      .init_o     (init_w[g]),
      .pend_o     (pend_w[g]),
      .mark_o     (mark_w[g])
    );
  end

  seq_guard_judge #(
    .N_SRC (N_SRC),
    .SEQ_W (SEQ_W),
    .SRC_W (SRC_W)
  ) u_judge (
    .pkt_valid_i (pkt_valid_i),
    .pkt_src_i   (pkt_src_i),
    .pkt_seq_i   (pkt_seq_i),
    .clear_i     (clear_i),
    .done_i      (done_i),
    .done_src_i  (done_src_i),
    .init_i      (init_w),
    .pend_i      (pend_w),
    .mark_i      (mark_w),
    .verdict_o   (verdict_w),
    .seed_o      (seed_w)
  );

  seq_guard_ack #(
    .SEQ_W  (SEQ_W),
    .SRC_W  (SRC_W),
    .ADDR_W (ADDR_W)
  ) u_ack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .verdict_i   (verdict_w),
    .src_i       (pkt_src_i),
    .seq_i       (pkt_seq_i),
    .saddr_i     (pkt_saddr_i),
    .daddr_i     (pkt_daddr_i),
    .accept_o    (accept_o),
    .drop_o      (drop_o),
    .ack_valid_o (ack_valid_o),
    .ack_src_o   (ack_src_o),
    .ack_seq_o   (ack_seq_o),
    .ack_saddr_o (ack_saddr_o),
    .ack_daddr_o (ack_daddr_o)
  );

  // R9: verdicts are exclusive and one per packet
  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && drop_o));
  a_r9_one_per_pkt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i |=> (accept_o ^ drop_o));
  a_r9_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_i |=> (!accept_o && !drop_o));

  // R8: acknowledgement mirrors the accepted packet with addresses exchanged
  a_r8_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (ack_valid_o && ack_seq_o == $past(pkt_seq_i) &&
                  ack_saddr_o == $past(pkt_daddr_i) && ack_daddr_o == $past(pkt_saddr_i)));
  a_r8_no_ack_on_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> !ack_valid_o);

endmodule

// File: tb/seq_guard_tb.sv
`timescale 1ns/1ps
module seq_guard_tb;

  localparam int N_SRC = 4;
  localparam int SRC_W = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic        pkt_valid_i = 1'b0;
  logic [1:0]  pkt_src_i = '0;
  logic [31:0] pkt_seq_i = '0;
  logic [31:0] pkt_saddr_i = '0;
  logic [31:0] pkt_daddr_i = '0;
  logic        done_i = 1'b0;
  logic [1:0]  done_src_i = '0;
  logic        accept_o, drop_o, ack_valid_o;
  logic [1:0]  ack_src_o;
  logic [31:0] ack_seq_o, ack_saddr_o, ack_daddr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench watermark model
  bit          m_init [N_SRC];
  bit          m_pend [N_SRC];
  logic [31:0] m_mark [N_SRC];

  always #2.5 clk_i = ~clk_i;

  seq_guard #(.N_SRC(N_SRC), .SEQ_W(32), .ADDR_W(32)) u_dut (
    .clk_i, .rst_ni, .clear_i, .pkt_valid_i, .pkt_src_i, .pkt_seq_i,
    .pkt_saddr_i, .pkt_daddr_i, .done_i, .done_src_i,
    .accept_o, .drop_o, .ack_valid_o, .ack_src_o, .ack_seq_o,
    .ack_saddr_o, .ack_daddr_o
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; drives, lets one edge pass, checks at the next negedge
  task automatic step(input bit v, input int src, input logic [31:0] seq,
                      input bit d, input int dsrc, input bit clr, input string tag);
    logic [31:0] sa, da, emark;
    bit einit, take;
    sa = seq ^ 32'h5A00_0000 ^ 32'(src);
    da = seq + 32'h0C30_0000 + 32'(src << 8);
    pkt_valid_i = v; pkt_src_i = SRC_W'(src); pkt_seq_i = seq;
    pkt_saddr_i = sa; pkt_daddr_i = da;
    done_i = d; done_src_i = SRC_W'(dsrc); clear_i = clr;
    einit = m_init[src] && !clr;
    emark = m_mark[src];
    if (d && dsrc == src && einit && !m_pend[src]) emark = emark + 1;
    take = v && (!einit || seq > emark);
    @(posedge clk_i);
    if (clr) begin
      for (int i = 0; i < N_SRC; i++) begin m_init[i] = 0; m_pend[i] = 0; end
    end else if (d && m_init[dsrc]) begin
      if (m_pend[dsrc]) m_pend[dsrc] = 0;
      else m_mark[dsrc] = m_mark[dsrc] + 1;
    end
    if (v && !einit) begin
      m_init[src] = 1; m_pend[src] = 1; m_mark[src] = seq;
    end
    @(negedge clk_i);
    cmp({tag, " R9 accept"}, 32'(accept_o), 32'(take));
    cmp({tag, " R9 drop"}, 32'(drop_o), 32'(v && !take));
    cmp({tag, " R8 ack_valid"}, 32'(ack_valid_o), 32'(take));
    if (take) begin
      cmp({tag, " R8 ack_seq"}, ack_seq_o, seq);
      cmp({tag, " R8 ack_src"}, 32'(ack_src_o), 32'(src));
      cmp({tag, " R8 ack_saddr"}, ack_saddr_o, da);
      cmp({tag, " R8 ack_daddr"}, ack_daddr_o, sa);
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < N_SRC; i++) begin m_init[i] = 0; m_pend[i] = 0; m_mark[i] = '0; end
    repeat (3) @(negedge clk_i);
    cmp("R1 accept in reset", 32'(accept_o), 0);
    cmp("R1 drop in reset", 32'(drop_o), 0);
    cmp("R1 ack in reset", 32'(ack_valid_o), 0);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R1 idle after reset");

    // R2 seeds with extreme values
    step(1, 0, 32'd0, 0, 0, 0, "R2 seed zero");
    step(1, 1, 32'hFFFF_FFFF, 0, 0, 0, "R2 seed max");
    step(1, 1, 32'hFFFF_FFFF, 0, 0, 0, "R3 max replay");
    step(1, 2, 32'd100, 0, 0, 0, "R2 seed 100");
    // R3 boundary around watermark
    step(1, 2, 32'd100, 0, 0, 0, "R3 equal");
    step(1, 2, 32'd99, 0, 0, 0, "R3 below");
    step(1, 2, 32'd101, 0, 0, 0, "R3 above");
    // R4 seed completion absorbed, then advance
    step(0, 0, 0, 1, 2, 0, "R4 done seed");
    step(1, 2, 32'd100, 0, 0, 0, "R4 unchanged after seed done");
    step(1, 2, 32'd101, 0, 0, 0, "R4 still accepts 101");
    step(0, 0, 0, 1, 2, 0, "R4 done advance");
    step(1, 2, 32'd101, 0, 0, 0, "R4 101 now replay");
    step(1, 2, 32'd102, 0, 0, 0, "R4 102 new");
    // R5 forwarding of coincident completion
    step(1, 2, 32'd102, 1, 2, 0, "R5 forward drop");
    step(1, 2, 32'd104, 1, 2, 0, "R5 forward accept");
    step(1, 2, 32'd103, 0, 0, 0, "R5 after forward");
    step(1, 2, 32'd103, 1, 0, 0, "R10 other-source done");
    // R6 completion on unset source
    step(0, 0, 0, 1, 3, 0, "R6 done unset");
    step(1, 3, 32'd0, 0, 0, 0, "R6 still first");
    // R10 independence
    step(1, 0, 32'd1, 0, 0, 0, "R10 src0 low seq");
    step(1, 0, 32'd0, 1, 0, 0, "R10 src0 replay");
    // R7 clear
    step(1, 2, 32'd3, 1, 2, 1, "R7 packet in clear");
    step(1, 1, 32'd0, 0, 0, 0, "R7 src1 first again");
    step(1, 2, 32'd3, 0, 0, 0, "R7 src2 reseeded");
    step(0, 0, 0, 1, 0, 1, "R7 done in clear");
    step(1, 0, 32'd50, 0, 0, 0, "R7 src0 first after clear");
    step(0, 0, 0, 0, 0, 1, "R7 clear before random");

    r = 32'hACE1_2357;
    for (int k = 0; k < 4000; k++) begin
      int src, dsrc;
      logic [31:0] seq;
      bit v, d, clr;
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      src  = int'(r[1:0]);
      dsrc = int'(r[5:4]);
      v    = r[7] | r[8];
      d    = r[9];
      clr  = (r[19:12] == 8'h3C);
      if (m_init[src]) seq = m_mark[src] + 32'(r[11:10]) + 32'(r[3]) - 32'd2;
      else             seq = {16'd0, r[31:16]} + 32'd8;
      step(v, src, seq, d, dsrc, clr, "R3 R10 random");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule